// File: doc/BRIEF.md
# Video Link Switch Configuration Slave (I2C)

This block lets an external I2C master program the small configuration register set of a two-input video link switch. It watches SCL and SDA, which a fast system clock has already synchronised. It recognises start, repeated start and stop conditions, compares the 7-bit device address against a fixed six-bit prefix plus one strap pin, and acknowledges the bytes addressed to it. The slave keeps an 8-bit register pointer, supports single-byte writes, and supports reads that return the register the pointer names.

A write is one bus transfer: start, device address with R/W = 0, pointer byte, data byte. Each accepted data byte to a mapped register raises a one-cycle strobe on the write port, carrying the register address and the value. Downstream logic uses that strobe to open its update window. A read sets the pointer with a write-type address phase, or keeps the pointer from an earlier transfer, and then issues a repeated start with R/W = 1. SDA is open-drain and is modelled as a pull-low enable.

Top module: `linkswitch_cfg_slave`

## Requirements
- R1: After reset, the registers read back 0x00→0x40, 0x01→0x40, 0x10→0x01, 0x11→0x00, 0x13→0x00, 0x20→0x03, and neither the SDA pull nor the write strobe is active.
- R2: The slave acknowledges a device address whose upper six bits are 100100 and whose lowest bit equals `addr_strap_i`, by pulling SDA low in the ninth clock.
- R3: On any other device address the slave gives no acknowledge, and it drives nothing and stores nothing until the next start condition.
- R4: In a write, the slave acknowledges the address byte, the pointer byte and the data byte, and the data is stored at the pointer. All bytes travel MSB first.
- R5: A data byte written to a mapped register produces exactly one `wr_stb_o` pulse of one cycle. In that cycle `wr_addr_o` holds the pointer and `wr_data_o` holds the byte. The pulse comes in the clock after the eighth data bit is sampled.
- R6: After a repeated start and the device address with R/W = 1, the slave shifts out the addressed register MSB first and then releases SDA for the master's acknowledge.
- R7: A read that follows a repeated start or a new start without a pointer phase returns the register named by the pointer already set.
- R8: A write to an unmapped address is acknowledged, is then discarded, and produces no strobe. A read of an unmapped address returns 0x00.
- R9: Only the defined bits are stored. In 0x00 and 0x01 these are bit 6 (enable) and bit 0 (source select). In 0x10 it is bit 0. In 0x20 they are bits 3:2 (pre-emphasis 00 = 0 dB, 01 = 2 dB, 10 = 4 dB, 11 = 6 dB), bit 1 (output termination on) and bit 0 (1 = 20 mA, 0 = 10 mA). All bits of 0x11 and 0x13 are stored. Every other bit reads 0.
- R10: The SDA pull changes only while SCL is low. It is inactive whenever the master drives an address or a data bit.
- R11: Asserting `rst_ni` low at any time restores every register to its default.
- R12: After the single data byte of a write, further bytes before a stop are not acknowledged and are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; restores register defaults |
| scl_i | input | 1 | Synchronised I2C clock line |
| sda_i | input | 1 | Synchronised I2C data line (wired bus value) |
| addr_strap_i | input | 1 | Lowest bit of the device address |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb_o | output | 1 | One-cycle commit strobe for a stored byte |
| wr_addr_o | output | 8 | Register address of the commit |
| wr_data_o | output | 8 | Data byte of the commit |

## Verification
A wrong protocol state shows up on SDA within one bit time. The acknowledge appears in the wrong slot or is missing, or read data is shifted by a bit, and the master sees that at the next SCL high. A corrupted pointer or register value is invisible until the next read of that register, so the bench reads back after every write and after reset. A strobe fired from a wrong state appears on the write port within one clock, and a per-clock monitor compares it against the queue of expected commits.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   localparam int unsigned LSC_BYTE_W = 8;
   localparam int unsigned LSC_CNT_W  = $clog2(LSC_BYTE_W);
   localparam int unsigned LSC_NREG   = 6;

   // register map, entry i in bits [i*8 +: 8]
   localparam logic [LSC_NREG*LSC_BYTE_W-1:0] LSC_MAP_ADDR =
      {8'h20, 8'h13, 8'h11, 8'h10, 8'h01, 8'h00};
   localparam logic [LSC_NREG*LSC_BYTE_W-1:0] LSC_MAP_DFLT =
      {8'h03, 8'h00, 8'h00, 8'h01, 8'h40, 8'h40};
   localparam logic [LSC_NREG*LSC_BYTE_W-1:0] LSC_MAP_MASK =
      {8'h0F, 8'hFF, 8'hFF, 8'h01, 8'h41, 8'h41};

   typedef logic [LSC_BYTE_W-1:0] lsc_byte_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_PTR,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_RACK
   } lsc_state_e;

endpackage

// File: rtl/lsc_bus_cond.sv
module lsc_bus_cond #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic scl_s, sda_s;
   logic scl_q, sda_q;

   if (STAGES == 0) begin : g_direct
      assign scl_s = scl_i;
      assign sda_s = sda_i;
   end else begin : g_pipe
      logic [STAGES-1:0] scl_p, sda_p;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            scl_p <= '1;
            sda_p <= '1;
         end else begin
            scl_p[0] <= scl_i;
            sda_p[0] <= sda_i;
            for (int k = 1; k < STAGES; k++) begin
               scl_p[k] <= scl_p[k-1];
               sda_p[k] <= sda_p[k-1];
            end
         end
      end
      assign scl_s = scl_p[STAGES-1];
      assign sda_s = sda_p[STAGES-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign sda_o      = sda_s;
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile
   import lsc_pkg::*;
#(
   parameter int unsigned                      NREG     = LSC_NREG,
   parameter logic [NREG*LSC_BYTE_W-1:0]       ADDR_MAP = LSC_MAP_ADDR,
   parameter logic [NREG*LSC_BYTE_W-1:0]       DFLT_MAP = LSC_MAP_DFLT,
   parameter logic [NREG*LSC_BYTE_W-1:0]       MASK_MAP = LSC_MAP_MASK
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  lsc_byte_t ptr_i,
   input  logic      wr_en_i,
   input  lsc_byte_t wr_data_i,
   output lsc_byte_t rdata_o,
   output logic      hit_o
);

   logic [NREG-1:0]                 sel;
   logic [NREG-1:0][LSC_BYTE_W-1:0] rv;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam lsc_byte_t A = ADDR_MAP[i*LSC_BYTE_W +: LSC_BYTE_W];
      localparam lsc_byte_t D = DFLT_MAP[i*LSC_BYTE_W +: LSC_BYTE_W];
      localparam lsc_byte_t M = MASK_MAP[i*LSC_BYTE_W +: LSC_BYTE_W];

      if ((D & ~M) != '0) begin : g_bad_dflt
         $error("default value sets bits outside the writable mask");
      end
      for (genvar j = i + 1; j < NREG; j++) begin : g_dup
         if (ADDR_MAP[j*LSC_BYTE_W +: LSC_BYTE_W] == A) begin : g_bad_addr
            $error("register address mapped twice");
         end
      end

      lsc_byte_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                    q <= D;
         else if (wr_en_i && ptr_i == A) q <= wr_data_i & M;
      end
      assign sel[i] = (ptr_i == A);
      assign rv[i]  = q;
   end

   always_comb begin
      rdata_o = '0;
      hit_o   = 1'b0;
      for (int i = 0; i < NREG; i++) begin
         if (sel[i]) begin
            rdata_o = rdata_o | rv[i];
            hit_o   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/lsc_engine.sv
module lsc_engine
   import lsc_pkg::*;
#(
   parameter logic [5:0] DEV_ADDR_HI = 6'b100100
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      scl_rise_i,
   input  logic      scl_fall_i,
   input  logic      start_i,
   input  logic      stop_i,
   input  logic      sda_i,
   input  logic      strap_i,
   input  logic      hit_i,
   input  lsc_byte_t rdata_i,
   output logic      pull_o,
   output lsc_byte_t ptr_o,
   output logic      wr_en_o,
   output lsc_byte_t wr_data_o
);

   localparam logic [LSC_CNT_W-1:0] LAST_BIT = LSC_CNT_W'(LSC_BYTE_W - 1);

   lsc_state_e           st, ack_nxt;
   logic [LSC_CNT_W-1:0] cnt;
   lsc_byte_t            sh, ptr, wdat;
   logic                 ack_half, pull, stb;
   lsc_byte_t            byte_in;

   assign byte_in = {sh[LSC_BYTE_W-2:0], sda_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st       <= ST_IDLE;
         ack_nxt  <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         ptr      <= '0;
         wdat     <= '0;
         ack_half <= 1'b0;
         pull     <= 1'b0;
         stb      <= 1'b0;
      end else begin
         stb <= 1'b0;
         if (start_i) begin
            st       <= ST_DEV;
            cnt      <= '0;
            pull     <= 1'b0;
            ack_half <= 1'b0;
         end else if (stop_i) begin
            st       <= ST_IDLE;
            pull     <= 1'b0;
            ack_half <= 1'b0;
         end else begin
            case (st)
               ST_DEV: if (scl_rise_i) begin
                  sh  <= byte_in;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (byte_in[LSC_BYTE_W-1:1] == {DEV_ADDR_HI, strap_i}) begin
                        st      <= ST_ACK;
                        ack_nxt <= byte_in[0] ? ST_RDAT : ST_PTR;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_PTR: if (scl_rise_i) begin
                  sh  <= byte_in;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     cnt     <= '0;
                     ptr     <= byte_in;
                     st      <= ST_ACK;
                     ack_nxt <= ST_WDAT;
                  end
               end
               ST_WDAT: if (scl_rise_i) begin
                  sh  <= byte_in;
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     cnt     <= '0;
                     wdat    <= byte_in;
                     stb     <= hit_i;
                     st      <= ST_ACK;
                     ack_nxt <= ST_IDLE;
                  end
               end
               ST_ACK: if (scl_fall_i) begin
                  if (!ack_half) begin
                     pull     <= 1'b1;
                     ack_half <= 1'b1;
                  end else begin
                     ack_half <= 1'b0;
                     st       <= ack_nxt;
                     cnt      <= '0;
                     if (ack_nxt == ST_RDAT) begin
                        sh   <= rdata_i;
                        pull <= ~rdata_i[LSC_BYTE_W-1];
                     end else begin
                        pull <= 1'b0;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_fall_i) begin
                     sh   <= {sh[LSC_BYTE_W-2:0], 1'b0};
                     pull <= ~sh[LSC_BYTE_W-2];
                  end
                  if (scl_rise_i) begin
                     cnt <= cnt + 1'b1;
                     if (cnt == LAST_BIT) begin
                        cnt <= '0;
                        st  <= ST_RACK;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall_i) pull <= 1'b0;
                  if (scl_rise_i) st   <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign pull_o    = pull;
   assign ptr_o     = ptr;
   assign wr_en_o   = stb;
   assign wr_data_o = wdat;

endmodule

// File: rtl/linkswitch_cfg_slave.sv
module linkswitch_cfg_slave
   import lsc_pkg::*;
#(
   parameter logic [5:0]  DEV_ADDR_HI = 6'b100100,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic                  addr_strap_i,
   output logic                  sda_pull_o,
   output logic                  wr_stb_o,
   output logic [LSC_BYTE_W-1:0] wr_addr_o,
   output logic [LSC_BYTE_W-1:0] wr_data_o
);

   if (SYNC_STAGES > 4) begin : g_bad_stages
      $error("SYNC_STAGES above 4 is not supported");
   end

   logic      sda_s, scl_rise, scl_fall, start, stop;
   logic      hit, wr_en;
   lsc_byte_t ptr, rdata, wdat;

   lsc_bus_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start),
      .stop_o     (stop)
   );

   lsc_engine #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_eng (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start),
      .stop_i     (stop),
      .sda_i      (sda_s),
      .strap_i    (addr_strap_i),
      .hit_i      (hit),
      .rdata_i    (rdata),
      .pull_o     (sda_pull_o),
      .ptr_o      (ptr),
      .wr_en_o    (wr_en),
      .wr_data_o  (wdat)
   );

   lsc_regfile u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ptr_i     (ptr),
      .wr_en_i   (wr_en),
      .wr_data_i (wdat),
      .rdata_o   (rdata),
      .hit_o     (hit)
   );

   assign wr_stb_o  = wr_en;
   assign wr_addr_o = ptr;
   assign wr_data_o = wdat;

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
   import lsc_pkg::*;
(
   input logic            clk_i,
   input logic            rst_ni,
   input logic            scl_i,
   input logic            sda_pull_o,
   input logic            wr_stb_o,
   input logic [LSC_BYTE_W-1:0] wr_addr_o
);

   function automatic logic is_mapped(input lsc_byte_t a);
      logic m = 1'b0;
      for (int i = 0; i < LSC_NREG; i++)
         if (LSC_MAP_ADDR[i*LSC_BYTE_W +: LSC_BYTE_W] == a) m = 1'b1;
      return m;
   endfunction

   // R5: commit strobe lasts one cycle
   p_stb_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_o |=> !wr_stb_o);

   // R8: no commit for unmapped addresses
   p_stb_mapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_o |-> is_mapped(wr_addr_o));

   // R10: pull engages only while SCL is low
   p_pull_rise_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sda_pull_o) |-> !scl_i);

   // R10: pull releases only while SCL is low
   p_pull_fall_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sda_pull_o) |-> !scl_i);

   // R4: data commit happens while the master owns SDA
   p_stb_no_pull_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_o |-> !sda_pull_o);

endmodule

bind linkswitch_cfg_slave lsc_checker u_lsc_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .scl_i      (scl_i),
   .sda_pull_o (sda_pull_o),
   .wr_stb_o   (wr_stb_o),
   .wr_addr_o  (wr_addr_o)
);

// File: tb/linkswitch_cfg_slave_tb_top.sv
module linkswitch_cfg_slave_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       strap = 1'b0;
   logic       sda_bus;
   logic       pull, wr_stb;
   logic [7:0] wr_addr, wr_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;
   bit prev_pull = 1'b0;

   logic [7:0]  mdl [256];
   logic [15:0] exp_q [$];

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~pull;

   linkswitch_cfg_slave dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .scl_i        (scl),
      .sda_i        (sda_bus),
      .addr_strap_i (strap),
      .sda_pull_o   (pull),
      .wr_stb_o     (wr_stb),
      .wr_addr_o    (wr_addr),
      .wr_data_o    (wr_data)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // masks and defaults taken from R1 and R9
   function automatic logic [7:0] req_mask(input logic [7:0] a);
      case (a)
         8'h00, 8'h01: return 8'h41;
         8'h10:        return 8'h01;
         8'h11, 8'h13: return 8'hFF;
         8'h20:        return 8'h0F;
         default:      return 8'h00;
      endcase
   endfunction

   function automatic void model_reset();
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
      mdl[8'h00] = 8'h40; mdl[8'h01] = 8'h40; mdl[8'h10] = 8'h01;
      mdl[8'h20] = 8'h03;
   endfunction

   // per-clock reference comparison of the commit port and SDA pull timing
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_stb) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected strobe", {wr_addr, wr_data}, 16'h0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check({wr_addr, wr_data} == e, "R5 strobe addr/data", {wr_addr, wr_data}, e);
            end
         end
         if (pull != prev_pull && scl)
            check(1'b0, "R10 pull changed while SCL high", {15'h0, pull}, {15'h0, prev_pull});
      end
      prev_pull = pull;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         check(1'b0, "watchdog expired", 16'h0, 16'h0);
         finish_run();
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; hold(2);
      scl   = 1'b1; hold(4);
      sda_m = 1'b0; hold(4);
      scl   = 1'b0; hold(2);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; hold(2);
      scl   = 1'b1; hold(4);
      sda_m = 1'b1; hold(4);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      bit clash = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hold(2);
         scl = 1'b1; hold(2);
         if (sda_bus != sda_m) clash = 1'b1;
         hold(2);
         scl = 1'b0; hold(2);
      end
      check(!clash, "R10 slave drove SDA during master bits", {15'h0, clash}, 16'h0);
      sda_m = 1'b1; hold(2);
      scl = 1'b1; hold(2);
      acked = (sda_bus == 1'b0);
      hold(2);
      scl = 1'b0; hold(2);
   endtask

   task automatic recv_byte(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; hold(2);
         scl = 1'b1; hold(2);
         b[i] = sda_bus;
         hold(2);
         scl = 1'b0; hold(2);
      end
      sda_m = 1'b0; hold(2);
      scl = 1'b1; hold(4);
      scl = 1'b0; hold(2);
      check(pull == 1'b0, "R6 SDA released after read byte", {15'h0, pull}, 16'h0);
   endtask

   function automatic logic [7:0] dev(input bit rw);
      return {6'b100100, strap, rw};
   endfunction

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      bit ack;
      if (req_mask(a) != 8'h00) exp_q.push_back({a, d});
      mdl[a] = d & req_mask(a);
      i2c_start();
      send_byte(dev(1'b0), ack); check(ack, "R4 address ack", {15'h0, ack}, 16'h1);
      send_byte(a, ack);         check(ack, "R4 pointer ack", {15'h0, ack}, 16'h1);
      send_byte(d, ack);         check(ack, "R4 data ack",    {15'h0, ack}, 16'h1);
      i2c_stop();
      check(exp_q.size() == 0, "R5 strobe count", exp_q.size(), 16'h0);
   endtask

   task automatic rd_reg(input logic [7:0] a, input string tag);
      bit ack;
      logic [7:0] v;
      i2c_start();
      send_byte(dev(1'b0), ack);
      send_byte(a, ack);
      i2c_start();
      send_byte(dev(1'b1), ack); check(ack, "R6 read address ack", {15'h0, ack}, 16'h1);
      recv_byte(v);
      i2c_stop();
      check(v == mdl[a], tag, {a, v}, {a, mdl[a]});
   endtask

   initial begin
      bit ack;
      logic [7:0] v;
      model_reset();
      hold(5);
      check(pull == 1'b0 && wr_stb == 1'b0, "R1 reset outputs idle", {pull, wr_stb}, 16'h0);
      rst_n = 1'b1;
      hold(5);

      // R1 defaults
      rd_reg(8'h00, "R1 default 0x00"); rd_reg(8'h01, "R1 default 0x01");
      rd_reg(8'h10, "R1 default 0x10"); rd_reg(8'h11, "R1 default 0x11");
      rd_reg(8'h13, "R1 default 0x13"); rd_reg(8'h20, "R1 default 0x20");

      // R4 full-byte registers
      wr_reg(8'h11, 8'hA5); rd_reg(8'h11, "R4 readback 0x11");
      wr_reg(8'h13, 8'h3C); rd_reg(8'h13, "R4 readback 0x13");

      // R9 defined-bit storage
      wr_reg(8'h00, 8'hFF); rd_reg(8'h00, "R9 mask 0x00");
      wr_reg(8'h01, 8'h01); rd_reg(8'h01, "R9 source select 0x01");
      wr_reg(8'h10, 8'hFE); rd_reg(8'h10, "R9 mask 0x10");
      wr_reg(8'h20, 8'hFF); rd_reg(8'h20, "R9 mask 0x20");
      wr_reg(8'h20, 8'h08); rd_reg(8'h20, "R9 4 dB, termination off, 10 mA");

      // R7 read from current pointer (0x20)
      i2c_start();
      send_byte(dev(1'b1), ack); check(ack, "R7 address ack", {15'h0, ack}, 16'h1);
      recv_byte(v);
      i2c_stop();
      check(v == 8'h08, "R7 current pointer read", v, 8'h08);

      // R8 unmapped
      wr_reg(8'h05, 8'h77); rd_reg(8'h05, "R8 unmapped reads zero");
      rd_reg(8'hFF, "R8 unmapped 0xFF reads zero");

      // R3 wrong address
      i2c_start();
      send_byte(8'h94, ack); check(!ack, "R3 wrong address not acked", {15'h0, ack}, 16'h0);
      send_byte(8'h11, ack); check(!ack, "R3 later byte not acked", {15'h0, ack}, 16'h0);
      send_byte(8'h99, ack); check(!ack, "R3 data byte not acked", {15'h0, ack}, 16'h0);
      i2c_stop();
      rd_reg(8'h11, "R3 register untouched");

      // R2 strap
      strap = 1'b1;
      wr_reg(8'h13, 8'hC3); rd_reg(8'h13, "R2 strap=1 write");
      i2c_start();
      send_byte(8'h90, ack); check(!ack, "R2 old strap address rejected", {15'h0, ack}, 16'h0);
      i2c_stop();

      // R12 extra byte after data
      exp_q.push_back({8'h11, 8'h5A}); mdl[8'h11] = 8'h5A;
      i2c_start();
      send_byte(dev(1'b0), ack);
      send_byte(8'h11, ack);
      send_byte(8'h5A, ack); check(ack, "R12 first data acked", {15'h0, ack}, 16'h1);
      send_byte(8'h66, ack); check(!ack, "R12 extra byte not acked", {15'h0, ack}, 16'h0);
      i2c_stop();
      rd_reg(8'h11, "R12 extra byte not stored");

      // R7 write then repeated start read without a pointer phase
      exp_q.push_back({8'h13, 8'h77}); mdl[8'h13] = 8'h77;
      i2c_start();
      send_byte(dev(1'b0), ack);
      send_byte(8'h13, ack);
      send_byte(8'h77, ack);
      i2c_start();
      send_byte(dev(1'b1), ack);
      recv_byte(v);
      i2c_stop();
      check(v == 8'h77, "R7 repeated start read", v, 8'h77);

      // R11 reset restores defaults
      hold(3);
      rst_n = 1'b0; hold(3); rst_n = 1'b1; hold(3);
      model_reset();
      rd_reg(8'h00, "R11 reset 0x00"); rd_reg(8'h01, "R11 reset 0x01");
      rd_reg(8'h10, "R11 reset 0x10"); rd_reg(8'h11, "R11 reset 0x11");
      rd_reg(8'h13, "R11 reset 0x13"); rd_reg(8'h20, "R11 reset 0x20");

      hold(10);
      done = 1'b1;
      finish_run();
   end

endmodule